// File: doc/BRIEF.md
# Synchronous Burst SRAM with Two-Bit Burst Sequencer

This block is a clocked word-wide memory with byte lanes and a built-in burst address sequencer. It suits a main store or a cache data array that is fed by either a processor or a memory controller. Address, write data, chip selects, both start strobes, the advance input and every write control are captured on the rising clock edge. A start strobe loads an external address. Later words of the burst are produced inside the block, and the low two address bits step through an aligned group of four in linear or interleaved order.

Reads are flow-through. The word at the current burst address is presented during the cycle that follows the edge that selected it, which gives 2-1-1-1 timing for a four-word read. Output enable and the sleep input act without waiting for the clock. Sleep freezes the control state, blocks every write and turns the outputs off. The stored data is kept. Because a tri-state bus cannot be modelled here, the data output comes with a drive qualifier: `dout_oe` low means high impedance, and `dout` then reads zero.

Top module: `sync_burst_sram`

## Requirements
- R1: A cycle is selected only when ce1_n=0, ce2=1 and ce3_n=0 at the edge. A start strobe seen on an unselected edge ends any burst, and dout_oe stays 0 until the next selected start. Advance cycles have no effect while no burst is open.
- R2: Either strobe (strb_cpu_n=0 or strb_ctl_n=0) on a selected edge loads addr. The word at that address appears on dout with dout_oe=1 in the cycle right after that edge.
- R3: On an edge with no strobe, adv_n=0 steps the two-bit beat counter by one. adv_n=1 keeps the same address.
- R4: The low two address bits equal start XOR beat when burst_ilv=1, and (start + beat) mod 4 when burst_ilv=0. Upper address bits never change inside a burst, and the fifth beat wraps back to the start word.
- R5: With bwe_n=0 and gwe_n=1, a write updates only the lanes i whose be_n[i]=0, where lane i is bits [8*i+7:8*i]. The other lanes keep their contents.
- R6: gwe_n=0 writes every lane, whatever the values of bwe_n and be_n.
- R7: A start made with strb_cpu_n=0 is a read, even when write controls are asserted or strb_ctl_n is also low. Writes in that burst happen on later advance or hold cycles. A start made with strb_ctl_n alone performs its write at the loaded address.
- R8: dout_oe is 0, and dout is 0, while oe_n=1 or when the last edge was a write. oe_n acts without a clock edge.
- R9: While sleep=1, dout_oe=0, no write happens and the burst state does not change. Once sleep=0, the burst resumes at the address it held.
- R10: A new external address can be loaded on every edge, and each word appears in the cycle after its own edge.
- R11: While rst_n=0 the burst is closed and dout_oe=0. Advance cycles after reset produce no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset of the burst state |
| addr | input | ADDR_W | External word address |
| din | input | BYTES*BYTE_W | Write data |
| ce1_n | input | 1 | Chip select, active low |
| ce2 | input | 1 | Chip select, active high |
| ce3_n | input | 1 | Chip select, active low |
| strb_cpu_n | input | 1 | Processor-side start strobe, active low |
| strb_ctl_n | input | 1 | Controller-side start strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gwe_n | input | 1 | Global write of all lanes, active low |
| bwe_n | input | 1 | Byte write master enable, active low |
| be_n | input | BYTES | Per-lane byte enables, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Asynchronous low-power hold, active high |
| burst_ilv | input | 1 | 1 selects interleaved order, 0 selects linear order |
| dout | output | BYTES*BYTE_W | Read data, zero when not driven |
| dout_oe | output | 1 | Output drive qualifier (0 means high impedance) |

## Verification
The hardest situation to reach is sleep raised in the middle of an open burst while the inputs present a new start with a write. A correct block must drop that start and that write and must keep its beat position. To reach it, the stimulus opens an interleaved burst on known data, raises sleep, and then drives a controller-strobe write and an advance-write to a word whose contents are known. After sleep is lowered, it checks that the same word is shown, that the next beat follows from the held position, and that the targeted word still holds its old value. A processor-strobe start carrying an asserted global write is handled the same way: the stimulus reads the word back and sees no change.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  // Low two address bits for a given burst beat.
  function automatic logic [1:0] burst_lo(input logic [1:0] first,
                                          input logic [1:0] beat,
                                          input logic       ilv);
    return ilv ? (first ^ beat) : (first + beat);
  endfunction
endpackage

// File: rtl/sbs_ctrl.sv
module sbs_ctrl #(
  parameter int ADDR_W = 8,
  parameter int BYTES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ce1_n,
  input  logic              ce2,
  input  logic              ce3_n,
  input  logic              strb_cpu_n,
  input  logic              strb_ctl_n,
  input  logic              adv_n,
  input  logic              gwe_n,
  input  logic              bwe_n,
  input  logic [BYTES-1:0]  be_n,
  input  logic              burst_ilv,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              active,
  output logic              rd_cyc,
  output logic              wr_fire,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [BYTES-1:0]  wr_mask,
  output logic              start_evt,
  output logic              desel_evt,
  output logic              adv_evt
);
  import sbs_pkg::*;

  logic [ADDR_W-1:2] hi_q;
  logic [1:0]        first_q, beat_q, beat_nxt;
  logic              active_q, rd_q;
  logic              awake, strobe, sel, cont_evt, wr_req;

  assign awake     = !sleep;
  assign strobe    = !strb_cpu_n || !strb_ctl_n;
  assign sel       = !ce1_n && ce2 && !ce3_n;
  assign start_evt = awake && strobe && sel;
  assign desel_evt = awake && strobe && !sel;
  assign cont_evt  = awake && !strobe && active_q;
  assign adv_evt   = cont_evt && !adv_n;
  assign beat_nxt  = adv_evt ? beat_q + 2'd1 : beat_q;

  // Global write overrides the byte-write path.
  always_comb begin
    if (!gwe_n)      wr_mask = '1;
    else if (!bwe_n) wr_mask = ~be_n;
    else             wr_mask = '0;
  end
  assign wr_req  = |wr_mask;
  assign wr_fire = (start_evt && strb_cpu_n && wr_req) || (cont_evt && wr_req);

  assign cur_addr = {hi_q, burst_lo(first_q, beat_q, burst_ilv)};
  assign wr_addr  = start_evt ? addr : {hi_q, burst_lo(first_q, beat_nxt, burst_ilv)};
  assign active   = active_q;
  assign rd_cyc   = rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q     <= '0;
      first_q  <= '0;
      beat_q   <= '0;
      active_q <= 1'b0;
      rd_q     <= 1'b0;
    end else if (start_evt) begin
      hi_q     <= addr[ADDR_W-1:2];
      first_q  <= addr[1:0];
      beat_q   <= '0;
      active_q <= 1'b1;
      rd_q     <= !wr_fire;
    end else if (desel_evt) begin
      active_q <= 1'b0;
      rd_q     <= 1'b0;
    end else if (cont_evt) begin
      beat_q   <= beat_nxt;
      rd_q     <= !wr_fire;
    end
  end
endmodule

// File: rtl/sbs_array.sv
module sbs_array #(
  parameter int ADDR_W = 8,
  parameter int BYTES  = 2,
  parameter int BYTE_W = 8
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic [BYTES-1:0]        mask,
  input  logic [ADDR_W-1:0]       waddr,
  input  logic [BYTES*BYTE_W-1:0] wdata,
  input  logic [ADDR_W-1:0]       raddr,
  output logic [BYTES*BYTE_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < BYTES; g++) begin : g_lane
    logic [BYTE_W-1:0] cells [DEPTH];
    always_ff @(posedge clk) begin
      if (we && mask[g]) cells[waddr] <= wdata[g*BYTE_W +: BYTE_W];
    end
    assign rdata[g*BYTE_W +: BYTE_W] = cells[raddr];
  end
endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram #(
  parameter int ADDR_W = 8,
  parameter int BYTES  = 2,
  parameter int BYTE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [BYTES*BYTE_W-1:0] din,
  input  logic                    ce1_n,
  input  logic                    ce2,
  input  logic                    ce3_n,
  input  logic                    strb_cpu_n,
  input  logic                    strb_ctl_n,
  input  logic                    adv_n,
  input  logic                    gwe_n,
  input  logic                    bwe_n,
  input  logic [BYTES-1:0]        be_n,
  input  logic                    oe_n,
  input  logic                    sleep,
  input  logic                    burst_ilv,
  output logic [BYTES*BYTE_W-1:0] dout,
  output logic                    dout_oe
);
  localparam int DATA_W = BYTES * BYTE_W;

  logic [ADDR_W-1:0] cur_addr, wr_addr;
  logic [BYTES-1:0]  wr_mask;
  logic [DATA_W-1:0] rdata;
  logic              active, rd_cyc, wr_fire, start_evt, desel_evt, adv_evt;

  sbs_ctrl #(.ADDR_W(ADDR_W), .BYTES(BYTES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .sleep(sleep), .addr(addr),
    .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
    .strb_cpu_n(strb_cpu_n), .strb_ctl_n(strb_ctl_n), .adv_n(adv_n),
    .gwe_n(gwe_n), .bwe_n(bwe_n), .be_n(be_n), .burst_ilv(burst_ilv),
    .cur_addr(cur_addr), .active(active), .rd_cyc(rd_cyc),
    .wr_fire(wr_fire), .wr_addr(wr_addr), .wr_mask(wr_mask),
    .start_evt(start_evt), .desel_evt(desel_evt), .adv_evt(adv_evt)
  );

  sbs_array #(.ADDR_W(ADDR_W), .BYTES(BYTES), .BYTE_W(BYTE_W)) u_array (
    .clk(clk), .we(wr_fire), .mask(wr_mask), .waddr(wr_addr),
    .wdata(din), .raddr(cur_addr), .rdata(rdata)
  );

  // Asynchronous output gating: output enable and sleep need no clock.
  assign dout_oe = active && rd_cyc && !oe_n && !sleep;
  assign dout    = dout_oe ? rdata : '0;
endmodule

// File: rtl/sbs_chk.sv
module sbs_chk #(
  parameter int ADDR_W = 8,
  parameter int BYTES  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sleep,
  input logic              oe_n,
  input logic [ADDR_W-1:0] addr,
  input logic              strb_cpu_n,
  input logic              strb_ctl_n,
  input logic              adv_n,
  input logic              gwe_n,
  input logic              dout_oe,
  input logic [ADDR_W-1:0] cur_addr,
  input logic              active,
  input logic              start_evt,
  input logic              desel_evt,
  input logic              adv_evt,
  input logic              wr_fire,
  input logic [BYTES-1:0]  wr_mask
);
  AST_DESEL_OFF: assert property (@(posedge clk) disable iff (!rst_n) desel_evt |=> !dout_oe); // R1
  AST_START_LOAD: assert property (@(posedge clk) disable iff (!rst_n) start_evt |=> cur_addr == $past(addr)); // R2
  AST_HOLD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && active && strb_cpu_n && strb_ctl_n && adv_n) |=> $stable(cur_addr)); // R3
  AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    adv_evt |=> cur_addr[ADDR_W-1:2] == $past(cur_addr[ADDR_W-1:2])); // R4
  AST_GLOBAL_ALL: assert property (@(posedge clk) disable iff (!rst_n) (wr_fire && !gwe_n) |-> &wr_mask); // R6
  AST_CPU_READ: assert property (@(posedge clk) disable iff (!rst_n) (start_evt && !strb_cpu_n) |-> !wr_fire); // R7
  AST_OE_GATE: assert property (@(posedge clk) disable iff (!rst_n) oe_n |-> !dout_oe); // R8
  AST_SLEEP_NOWR: assert property (@(posedge clk) disable iff (!rst_n) sleep |-> (!wr_fire && !dout_oe)); // R9
  AST_SLEEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n) sleep |=> $stable(cur_addr) && $stable(active)); // R9
endmodule

bind sync_burst_sram sbs_chk #(.ADDR_W(ADDR_W), .BYTES(BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .sleep(sleep), .oe_n(oe_n), .addr(addr),
  .strb_cpu_n(strb_cpu_n), .strb_ctl_n(strb_ctl_n), .adv_n(adv_n),
  .gwe_n(gwe_n), .dout_oe(dout_oe), .cur_addr(cur_addr), .active(active),
  .start_evt(start_evt), .desel_evt(desel_evt), .adv_evt(adv_evt),
  .wr_fire(wr_fire), .wr_mask(wr_mask)
);

// File: tb/sync_burst_sram_tb.sv
module sync_burst_sram_tb;
  localparam int AW = 8;
  localparam int NB = 2;
  localparam int DW = 16;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] din, dout;
  logic          ce1_n, ce2, ce3_n, strb_cpu_n, strb_ctl_n, adv_n;
  logic          gwe_n, bwe_n, oe_n, sleep, burst_ilv, dout_oe;
  logic [NB-1:0] be_n;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  sync_burst_sram #(.ADDR_W(AW), .BYTES(NB), .BYTE_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .din(din),
    .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
    .strb_cpu_n(strb_cpu_n), .strb_ctl_n(strb_ctl_n), .adv_n(adv_n),
    .gwe_n(gwe_n), .bwe_n(bwe_n), .be_n(be_n), .oe_n(oe_n),
    .sleep(sleep), .burst_ilv(burst_ilv), .dout(dout), .dout_oe(dout_oe)
  );

  // ops: 0 hold, 1 ctl read start, 2 cpu start, 3 ctl global-write start,
  //      4 advance read, 5 advance global write, 6 unselected ctl strobe
  typedef struct packed {
    logic [3:0]    op;
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    logic          oe;
    logic [DW-1:0] q;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t TBL [NV] = '{
    '{4'd3, 8'h10, 16'h1111, 1'b0, 16'h0000},
    '{4'd5, 8'h00, 16'h2222, 1'b0, 16'h0000},
    '{4'd5, 8'h00, 16'h3333, 1'b0, 16'h0000},
    '{4'd5, 8'h00, 16'h4444, 1'b0, 16'h0000},
    '{4'd1, 8'h10, 16'h0000, 1'b1, 16'h1111},
    '{4'd4, 8'h00, 16'h0000, 1'b1, 16'h2222},
    '{4'd4, 8'h00, 16'h0000, 1'b1, 16'h3333},
    '{4'd4, 8'h00, 16'h0000, 1'b1, 16'h4444},
    '{4'd4, 8'h00, 16'h0000, 1'b1, 16'h1111},
    '{4'd0, 8'h00, 16'h0000, 1'b1, 16'h1111},
    '{4'd2, 8'h13, 16'h0000, 1'b1, 16'h4444},
    '{4'd4, 8'h00, 16'h0000, 1'b1, 16'h3333},
    '{4'd4, 8'h00, 16'h0000, 1'b1, 16'h2222},
    '{4'd4, 8'h00, 16'h0000, 1'b1, 16'h1111}
  };

  task automatic idle();
    ce1_n = 1'b0; ce2 = 1'b1; ce3_n = 1'b0;
    strb_cpu_n = 1'b1; strb_ctl_n = 1'b1; adv_n = 1'b1;
    gwe_n = 1'b1; bwe_n = 1'b1; be_n = '1; addr = '0; din = '0;
  endtask

  task automatic apply(input logic [3:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d);
    idle();
    addr = a; din = d;
    case (op)
      4'd1: strb_ctl_n = 1'b0;
      4'd2: strb_cpu_n = 1'b0;
      4'd3: begin strb_ctl_n = 1'b0; gwe_n = 1'b0; end
      4'd4: adv_n = 1'b0;
      4'd5: begin adv_n = 1'b0; gwe_n = 1'b0; end
      4'd6: begin strb_ctl_n = 1'b0; ce2 = 1'b0; end
      default: ;
    endcase
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic eo, input logic [DW-1:0] eq);
    checks++;
    if ({dout_oe, dout} !== {eo, eq}) begin
      errors++;
      $display("FAIL %s: got oe=%0b q=%h expected oe=%0b q=%h", req, dout_oe, dout, eo, eq);
    end
  endtask

  task automatic run(input logic [3:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d,
                     input string req, input logic eo, input logic [DW-1:0] eq);
    apply(op, a, d);
    step();
    check(req, eo, eq);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got oe=%0b q=%h expected completion", dout_oe, dout);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle();
    rst_n = 1'b0; oe_n = 1'b0; sleep = 1'b0; burst_ilv = 1'b1;
    repeat (2) @(negedge clk);
    check("R11 reset", 1'b0, '0);
    rst_n = 1'b1;

    // Table: writes, interleaved burst reads, wrap, hold, cpu-start burst (R2 R3 R4 R8)
    for (int i = 0; i < NV; i++) begin
      run(TBL[i].op, TBL[i].a, TBL[i].d, "R3 R4 table", TBL[i].oe, TBL[i].q);
    end

    // R4 linear order from start 3: 3,0,1,2
    apply(4'd2, 8'h13, '0); burst_ilv = 1'b0; step(); check("R4 linear", 1'b1, 16'h4444);
    run(4'd4, '0, '0, "R4 linear", 1'b1, 16'h1111);
    run(4'd4, '0, '0, "R4 linear", 1'b1, 16'h2222);
    run(4'd4, '0, '0, "R4 linear", 1'b1, 16'h3333);

    // R5 byte write of lane 0 only
    idle(); burst_ilv = 1'b1; strb_ctl_n = 1'b0; addr = 8'h10; bwe_n = 1'b0; be_n = 2'b10; din = 16'hABCD;
    step(); check("R8 write cycle", 1'b0, '0);
    run(4'd1, 8'h10, '0, "R5", 1'b1, 16'h11CD);

    // R6 global write overrides byte enables
    idle(); strb_ctl_n = 1'b0; addr = 8'h11; gwe_n = 1'b0; bwe_n = 1'b0; be_n = 2'b01; din = 16'h5A5A;
    step(); check("R8 write cycle", 1'b0, '0);
    run(4'd1, 8'h11, '0, "R6", 1'b1, 16'h5A5A);

    // R7 cpu strobe start ignores write controls; write lands on advance
    idle(); strb_cpu_n = 1'b0; addr = 8'h12; gwe_n = 1'b0; din = 16'hFFFF;
    step(); check("R7 cpu start read", 1'b1, 16'h3333);
    run(4'd5, '0, 16'h7777, "R8 write cycle", 1'b0, '0);
    run(4'd1, 8'h13, '0, "R7 advance write", 1'b1, 16'h7777);
    run(4'd1, 8'h12, '0, "R7 unchanged", 1'b1, 16'h3333);
    idle(); strb_cpu_n = 1'b0; strb_ctl_n = 1'b0; gwe_n = 1'b0; addr = 8'h11; din = '0;
    step(); check("R7 both strobes", 1'b1, 16'h5A5A);

    // R1 selection
    run(4'd6, 8'h10, '0, "R1 deselect", 1'b0, '0);
    run(4'd0, '0, '0, "R1 hold", 1'b0, '0);
    run(4'd4, '0, '0, "R1 advance idle", 1'b0, '0);
    idle(); strb_ctl_n = 1'b0; ce3_n = 1'b1; addr = 8'h10; step(); check("R1 ce3", 1'b0, '0);
    idle(); strb_cpu_n = 1'b0; ce1_n = 1'b1; addr = 8'h10; step(); check("R1 ce1", 1'b0, '0);

    // R8 asynchronous output enable
    run(4'd1, 8'h10, '0, "R2", 1'b1, 16'h11CD);
    oe_n = 1'b1; #1 check("R8 oe high", 1'b0, '0);
    oe_n = 1'b0; #1 check("R8 oe low", 1'b1, 16'h11CD);

    // R9 sleep mid-burst with start and writes presented
    sleep = 1'b1; #1 check("R9 sleep off", 1'b0, '0);
    apply(4'd3, 8'h13, 16'hDEAD); step(); check("R9 start ignored", 1'b0, '0);
    apply(4'd5, '0, 16'hBEEF); step(); check("R9 write ignored", 1'b0, '0);
    idle(); sleep = 1'b0; #1 check("R9 resume", 1'b1, 16'h11CD);
    run(4'd4, '0, '0, "R9 continue", 1'b1, 16'h5A5A);
    run(4'd1, 8'h13, '0, "R9 retained", 1'b1, 16'h7777);
    run(4'd1, 8'h10, '0, "R9 retained", 1'b1, 16'h11CD);

    // R10 new address every cycle
    run(4'd1, 8'h12, '0, "R10", 1'b1, 16'h3333);
    run(4'd2, 8'h11, '0, "R10", 1'b1, 16'h5A5A);
    run(4'd1, 8'h13, '0, "R10", 1'b1, 16'h7777);

    // R11 reset mid-burst
    rst_n = 1'b0; #1 check("R11 reset mid", 1'b0, '0);
    step(); rst_n = 1'b1;
    run(4'd4, '0, '0, "R11 after reset", 1'b0, '0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule